// File: doc/BRIEF.md
# Crossing History Pipeline With Dual Capture

This block delays a data word through a history shift register that advances once per crossing clock. The accept decision for a crossing arrives several crossings after the data itself. While that decision is pending, the data waits in the history register. Two programmable stages are tapped. Tap A feeds two holding registers that do not depend on each other. Tap B is brought out as a second delayed copy, so that a later pipeline stage can use a different latency.

The event holding register loads from tap A on any crossing edge where the active-low event-capture strobe is low. The monitor holding register loads from the same tap. Its load strobe is formed inside the block from two requests:

- An immediate request, which lasts one tick.
- An armed request. It causes a capture on the next accept only.

Both holding registers keep their value until the next load. Each monitor capture marks the monitor data as pending until software acknowledges it. A capture that arrives while data is still pending sets a sticky overrun flag.

A small read port with an address and a data bus returns the two holding registers and a status word.

Top module: `xhist_capture`

## Requirements
- R1: While rstN is low, the history stages, both holding registers, the pending flag and the overrun flag are cleared, so every read address returns zero.
- R2: After each clock edge, tapOutA equals dataIn as sampled tapSelA+1 edges earlier, and tapOutB equals dataIn as sampled tapSelB+1 edges earlier. Stages that have not yet been filled since reset read as zero.
- R3: At an edge where evtCaptureN is 0, the event holding register takes the tap A value present just before that edge.
- R4: At an edge where evtCaptureN is 1, the event holding register keeps its value.
- R5: At an edge where capNowReq is 1, the monitor holding register takes the tap A value present just before that edge.
- R6: At an edge where acceptIn and armReq are both 1, a monitor capture happens. An accept with armReq at 0 does not cause one.
- R7: One assertion of armReq yields at most one armed capture. Further accepts while armReq stays high capture nothing until armReq has been 0 for at least one edge.
- R8: When an immediate request and an armed accept fall on the same edge, only a single capture happens. That capture does not by itself set the overrun flag.
- R9: The two holding registers are independent. An event capture leaves the monitor register unchanged, and a monitor capture leaves the event register unchanged.
- R10: Each monitor capture sets the pending flag. A capture while pending is set and monAck is 0 sets the overrun flag. monAck clears both flags unless a capture happens on the same edge; in that case pending stays set and overrun is cleared.
- R11: rdData is combinational on rdAddr:
  - address 0 returns the event holding register;
  - address 1 returns the monitor holding register;
  - address 2 returns status, with pending in bit 0, overrun in bit 1 and zeros above;
  - address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 16 | Data word for the current crossing |
| tapSelA | input | 5 | Stage index of tap A (delay = value + 1) |
| tapSelB | input | 5 | Stage index of tap B (delay = value + 1) |
| evtCaptureN | input | 1 | Event capture strobe, active low |
| acceptIn | input | 1 | Accept decision for a crossing |
| capNowReq | input | 1 | Immediate monitor capture request |
| armReq | input | 1 | Request a monitor capture at the next accept |
| monAck | input | 1 | Software acknowledge of the monitor data |
| rdAddr | input | 2 | Read port address |
| tapOutA | output | 16 | History value at tap A |
| tapOutB | output | 16 | History value at tap B |
| rdData | output | 16 | Read port data |

## Verification
Two pairs of events can land on the same crossing edge:

- An immediate request and an armed accept.
- A monitor capture and a software acknowledge.

Directed steps drive both inputs of each pair in one cycle. After the edge, the bench reads the status word and the monitor register. It expects a single capture, so pending is set and overrun stays clear, and it expects the monitor register to hold the tap value from just before that edge. A seeded random phase then lets capture, accept, arm and acknowledge pulses collide freely. Every read is compared with a reference model kept in bench functions.

// File: rtl/xhist_pkg.sv
package xhist_pkg;

  // Load strobes handed from control to datapath
  typedef struct packed {
    logic evtLoad;
    logic monLoad;
  } xhStrobe_t;

  // Read port address map
  typedef enum logic [1:0] {
    RD_EVT  = 2'd0,
    RD_MON  = 2'd1,
    RD_STAT = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  localparam int STAT_PEND_BIT = 0;
  localparam int STAT_OVR_BIT  = 1;

endpackage

// File: rtl/xhist_ctrl.sv
module xhist_ctrl
  import xhist_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtCaptureN,
  input  logic       acceptIn,
  input  logic       capNowReq,
  input  logic       armReq,
  input  logic       monAck,
  output xhStrobe_t  strobes,
  output logic       pendingFlag,
  output logic       overrunFlag
);

  logic armSpent;
  logic armedHit;
  logic monLoad;

  // An armed request fires once, on the first accept it sees
  assign armedHit = acceptIn & armReq & ~armSpent;
  assign monLoad  = capNowReq | armedHit;

  assign strobes.evtLoad = ~evtCaptureN;
  assign strobes.monLoad = monLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armSpent <= 1'b0;
    end else if (!armReq) begin
      armSpent <= 1'b0;
    end else if (armedHit) begin
      armSpent <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingFlag <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      if (monLoad) begin
        pendingFlag <= 1'b1;
      end else if (monAck) begin
        pendingFlag <= 1'b0;
      end
      if (monLoad && pendingFlag && !monAck) begin
        overrunFlag <= 1'b1;
      end else if (monAck) begin
        overrunFlag <= 1'b0;
      end
    end
  end

  // R10
  ovr_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $past(pendingFlag));

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (monAck && !monLoad) |=> (!pendingFlag && !overrunFlag));

  // R7
  arm_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptIn && armReq && !armSpent) |=> armSpent);

  // R10
  capture_sets_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    monLoad |=> pendingFlag);

endmodule

// File: rtl/xhist_datapath.sv
module xhist_datapath
  import xhist_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int TAP_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [TAP_W-1:0]  tapSel [2],
  input  xhStrobe_t         strobes,
  input  logic              pendingFlag,
  input  logic              overrunFlag,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] tapOut [2],
  output logic [DATA_W-1:0] rdData
);

  localparam int LAST = DEPTH - 1;

  logic [DATA_W-1:0] stage [DEPTH];
  logic [DATA_W-1:0] evtHold;
  logic [DATA_W-1:0] monHold;

  // History shift register, one step per crossing edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= dataIn;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  // Programmable taps; an out-of-range index clamps to the last stage
  for (genvar t = 0; t < 2; t++) begin : g_tap
    always_comb begin
      if (int'(tapSel[t]) < DEPTH) tapOut[t] = stage[tapSel[t]];
      else                         tapOut[t] = stage[LAST];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtHold <= '0;
    end else if (strobes.evtLoad) begin
      evtHold <= tapOut[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monHold <= '0;
    end else if (strobes.monLoad) begin
      monHold <= tapOut[0];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel_e'(rdAddr))
      RD_EVT:  rdData = evtHold;
      RD_MON:  rdData = monHold;
      RD_STAT: begin
        rdData[STAT_PEND_BIT] = pendingFlag;
        rdData[STAT_OVR_BIT]  = overrunFlag;
      end
      RD_NONE: rdData = '0;
    endcase
  end

  // R4
  evt_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.evtLoad |=> $stable(evtHold));

  // R3
  evt_hold_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evtLoad |=> (evtHold == $past(tapOut[0])));

  // R9
  mon_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.monLoad |=> $stable(monHold));

  // R5
  mon_hold_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.monLoad |=> (monHold == $past(tapOut[0])));

endmodule

// File: rtl/xhist_capture.sv
module xhist_capture
  import xhist_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int TAP_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [TAP_W-1:0]  tapSelA,
  input  logic [TAP_W-1:0]  tapSelB,
  input  logic              evtCaptureN,
  input  logic              acceptIn,
  input  logic              capNowReq,
  input  logic              armReq,
  input  logic              monAck,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] tapOutA,
  output logic [DATA_W-1:0] tapOutB,
  output logic [DATA_W-1:0] rdData
);

  xhStrobe_t         strobes;
  logic              pendingFlag;
  logic              overrunFlag;
  logic [TAP_W-1:0]  tapSel [2];
  logic [DATA_W-1:0] tapOut [2];

  assign tapSel[0] = tapSelA;
  assign tapSel[1] = tapSelB;
  assign tapOutA   = tapOut[0];
  assign tapOutB   = tapOut[1];

  xhist_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evtCaptureN (evtCaptureN),
    .acceptIn    (acceptIn),
    .capNowReq   (capNowReq),
    .armReq      (armReq),
    .monAck      (monAck),
    .strobes     (strobes),
    .pendingFlag (pendingFlag),
    .overrunFlag (overrunFlag)
  );

  xhist_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .TAP_W  (TAP_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .dataIn      (dataIn),
    .tapSel      (tapSel),
    .strobes     (strobes),
    .pendingFlag (pendingFlag),
    .overrunFlag (overrunFlag),
    .rdAddr      (rdAddr),
    .tapOut      (tapOut),
    .rdData      (rdData)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (rdData == '0));

endmodule

// File: tb/sim_xhist_capture.sv
`timescale 1ns/1ps
module sim_xhist_capture;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dataIn = '0;
  logic [4:0]  tapSelA = '0, tapSelB = '0;
  logic        evtCaptureN = 1'b1, acceptIn = 1'b0, capNowReq = 1'b0;
  logic        armReq = 1'b0, monAck = 1'b0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] tapOutA, tapOutB, rdData;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  // Reference model state
  int          edges = 0;
  logic [15:0] samp [0:4095];
  logic [15:0] expEvt = '0, expMon = '0;
  logic        expPend = 0, expOvr = 0, expSpent = 0;

  always #2.5 clk = ~clk;

  xhist_capture u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .tapSelA(tapSelA), .tapSelB(tapSelB),
    .evtCaptureN(evtCaptureN), .acceptIn(acceptIn), .capNowReq(capNowReq),
    .armReq(armReq), .monAck(monAck), .rdAddr(rdAddr),
    .tapOutA(tapOutA), .tapOutB(tapOutB), .rdData(rdData)
  );

  // History value at stage k after edge n (dataIn sampled at edge n-k)
  function automatic logic [15:0] histAt(int k, int n);
    if (n - k >= 1) return samp[n - k];
    return 16'h0000;
  endfunction

  function automatic logic [15:0] expRead(logic [1:0] a);
    case (a)
      2'd0: return expEvt;
      2'd1: return expMon;
      2'd2: return {14'b0, expOvr, expPend};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One crossing edge; model updated from inputs held across the edge
  task automatic step();
    logic hit, mld;
    @(posedge clk);
    edges++;
    samp[edges] = dataIn;
    hit = acceptIn && armReq && !expSpent;
    mld = capNowReq || hit;
    if (!evtCaptureN) expEvt = histAt(int'(tapSelA), edges - 1);
    if (mld) expMon = histAt(int'(tapSelA), edges - 1);
    if (mld && expPend && !monAck) expOvr = 1'b1;
    else if (monAck) expOvr = 1'b0;
    if (mld) expPend = 1'b1;
    else if (monAck) expPend = 1'b0;
    if (!armReq) expSpent = 1'b0;
    else if (hit) expSpent = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    evtCaptureN = 1'b1; acceptIn = 1'b0; capNowReq = 1'b0; monAck = 1'b0;
  endtask

  task automatic readChk(string req, logic [1:0] a);
    rdAddr = a;
    #0.5;
    chk(req, rdData, expRead(a));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    logic [15:0] snap;
    for (int i = 0; i < 4096; i++) samp[i] = '0;
    void'($urandom(32'h5eed1234));

    // R1 reset state
    dataIn = 16'hA5A5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    readChk("R1 evt", 2'd0);
    readChk("R1 mon", 2'd1);
    readChk("R1 stat", 2'd2);
    chk("R1 tapA", tapOutA, 16'h0000);
    rstN = 1'b1;

    // R2 taps
    tapSelA = 5'd3; tapSelB = 5'd7;
    for (int i = 0; i < 20; i++) begin
      dataIn = 16'h1000 + 16'(i);
      step();
      chk("R2 tapA", tapOutA, histAt(3, edges));
      chk("R2 tapB", tapOutB, histAt(7, edges));
    end

    // R3 event capture
    evtCaptureN = 1'b0; dataIn = 16'h2222;
    step(); idle();
    chk("R3 model", expEvt, 16'h1000 + 16'd16);
    readChk("R3 evt", 2'd0);
    // R9 monitor untouched by event capture
    readChk("R9 mon", 2'd1);

    // R4 hold without strobe
    snap = expEvt;
    for (int i = 0; i < 6; i++) begin dataIn = 16'h3000 + 16'(i); step(); end
    readChk("R4 evt", 2'd0);
    chk("R4 snap", rdData, snap);

    // R5 immediate capture
    snap = expEvt;
    capNowReq = 1'b1; step(); idle();
    readChk("R5 mon", 2'd1);
    readChk("R9 evt", 2'd0);
    chk("R9 evt snap", rdData, snap);

    // ack, then accept without arm does nothing
    monAck = 1'b1; step(); idle();
    readChk("R10 ack", 2'd2);
    snap = expMon;
    dataIn = 16'h4444;
    acceptIn = 1'b1; step(); idle();
    readChk("R6 noarm", 2'd1);
    chk("R6 noarm snap", rdData, snap);
    readChk("R6 noarm stat", 2'd2);

    // R6 armed accept
    armReq = 1'b1; step();
    dataIn = 16'h5555; step();
    acceptIn = 1'b1; step(); idle();
    readChk("R6 armed", 2'd1);
    readChk("R6 stat", 2'd2);
    monAck = 1'b1; step(); idle();

    // R7 further accepts while arm stays high
    snap = expMon;
    for (int i = 0; i < 4; i++) begin
      dataIn = 16'h6000 + 16'(i);
      acceptIn = 1'b1; step(); idle(); step();
    end
    readChk("R7 no recapture", 2'd1);
    chk("R7 snap", rdData, snap);
    readChk("R7 stat", 2'd2);
    armReq = 1'b0; step();
    armReq = 1'b1; dataIn = 16'h7777; step();
    acceptIn = 1'b1; step(); idle();
    readChk("R7 rearm", 2'd1);
    monAck = 1'b1; step(); idle();
    armReq = 1'b0; step();

    // R8 immediate request and armed accept on the same edge
    armReq = 1'b1; step();
    capNowReq = 1'b1; acceptIn = 1'b1; dataIn = 16'h8888; step(); idle();
    readChk("R8 stat", 2'd2);
    chk("R8 stat value", rdData, 16'h0001);
    readChk("R8 mon", 2'd1);
    armReq = 1'b0;

    // R10 overrun
    capNowReq = 1'b1; step(); idle();
    readChk("R10 ovr", 2'd2);
    chk("R10 ovr value", rdData, 16'h0003);
    monAck = 1'b1; step(); idle();
    readChk("R10 cleared", 2'd2);
    chk("R10 cleared value", rdData, 16'h0000);
    capNowReq = 1'b1; step(); idle();
    capNowReq = 1'b1; monAck = 1'b1; step(); idle();
    readChk("R10 cap+ack", 2'd2);
    chk("R10 cap+ack value", rdData, 16'h0001);

    // R11 unused address
    readChk("R11 addr3", 2'd3);

    // Random phase
    for (int i = 0; i < 2500; i++) begin
      dataIn      = 16'($urandom);
      if ($urandom_range(0, 49) == 0) tapSelA = 5'($urandom);
      if ($urandom_range(0, 49) == 0) tapSelB = 5'($urandom);
      evtCaptureN = ($urandom_range(0, 7) != 0);
      capNowReq   = ($urandom_range(0, 15) == 0);
      acceptIn    = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 19) == 0) armReq = ~armReq;
      monAck      = ($urandom_range(0, 9) == 0);
      step();
      chk("R2 rand tapA", tapOutA, histAt(int'(tapSelA), edges));
      chk("R2 rand tapB", tapOutB, histAt(int'(tapSelB), edges));
      readChk("R11 rand read", 2'($urandom));
    end

    finish();
  end

endmodule